// File: doc/BRIEF.md
# Eight-Bit I/O Port With Edge Interrupts

This block controls one port of general-purpose pins. Each bit is set up through a small register file on a simple write/read bus. A bit works in one of two ways. It can be plain I/O, driven from the output and direction registers. Or it can hand its pad to a peripheral, which then supplies the output value and, on bits that support it, the output enable. Pad levels pass through a two-flop synchronizer. The synchronized value is readable by software and also goes to the peripheral input.

Every bit can raise an interrupt flag on an edge that software chooses. The flags stay set until software clears them. Software can also set a flag by writing to it. A single request line is the OR of every flag whose enable bit is set. Each bit has an analog-disable input that switches off the pad driver, the pull resistor and the digital input path, so that an analog signal on the pin causes no cross current.

After reset, a small state machine runs. It stays in `ST_WARM` until the synchronizer and the edge-history flops have filled, then moves to `ST_RUN`. Edges are counted only in `ST_RUN`. This is the only transition, `ST_WARM -> ST_RUN`, and it happens once after each reset.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the output, direction, flag, edge-select, enable, function-select and resistor registers all read 0. `pad_oe` is 0 and `irq` is 0.
- R2: The register address map is: 0 input (read-only), 1 output, 2 direction, 3 flag, 4 edge select, 5 interrupt enable, 6 function select, 7 resistor enable. A write to addresses 1 to 7 reads back the written value. A write to address 0 has no effect.
- R3: The input register and `per_in` show the pad level two rising clock edges after it changes.
- R4: With function select 0, `pad_oe` equals the direction bit (1 = output) and `pad_out` equals the output-register bit.
- R5: With function select 1, `pad_out` equals `per_out`. `pad_oe` equals `per_dir` on bits set in parameter `PERIPH_DIR_MASK` (default 8'h0F), and equals the direction bit on the other bits.
- R6: `pad_pull_en` is 1 only when the resistor bit is 1, the effective direction is input, and analog disable is 0. `pad_pull_up` equals the output-register bit (1 = pull up, 0 = pull down).
- R7: With edge select 0, a rising pad edge sets the bit's flag. With edge select 1, a falling edge sets it. The flag is readable after the third rising clock edge that follows the pad change, and not after the second. The opposite edge leaves the flag unchanged.
- R8: Changing an edge-select bit does not by itself set a flag.
- R9: A flag-register write stores the written value, so 0 clears a flag and 1 sets it. An edge that arrives in the same cycle as a 0 write still sets its flag.
- R10: `irq` is 1 exactly when some bit has both its flag and its enable set.
- R11: While a bit's analog disable is 1, its `pad_oe` and `pad_pull_en` are 0, its input bit reads 0, and pad edges on it set no flag.
- R12: Pad levels present during reset set no flag when the edge logic starts up (`ST_WARM` to `ST_RUN`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| pad_in | input | WIDTH | Raw pad levels |
| ana_dis | input | WIDTH | Per-bit analog disable |
| per_out | input | WIDTH | Peripheral output values |
| per_dir | input | WIDTH | Peripheral output enables |
| per_in | output | WIDTH | Synchronized input to the peripheral |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |
| pad_pull_en | output | WIDTH | Pull resistor enable |
| pad_pull_up | output | WIDTH | Pull direction, 1 = up |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable and known whenever `bus_we` is high. They also assume that pad, peripheral and analog-disable inputs change away from the active clock edge. The bench drives every input just after a falling clock edge and raises the write strobe for exactly one rising edge per access, so both assumptions always hold. The flag assertions also assume that a flag can come only from a bus write or from an edge seen by the edge detector. The bench never forces the internal state, so any other source of a flag would be a real fault.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_IN   = 3'd0,
        RA_OUT  = 3'd1,
        RA_DIR  = 3'd2,
        RA_FLAG = 3'd3,
        RA_EDGE = 3'd4,
        RA_IEN  = 3'd5,
        RA_FSEL = 3'd6,
        RA_RES  = 3'd7
    } gpio_reg_e;

    typedef enum logic {
        ST_WARM = 1'b0,
        ST_RUN  = 1'b1
    } edge_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else if (STAGES == 1) begin
                chain_q <= async_in[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gpio_edge.sv
module gpio_edge
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] ana_dis,
    input  logic [WIDTH-1:0] fall_sel,
    output logic [WIDTH-1:0] edge_hit,
    output logic             run
);

    localparam int CNT_W = $clog2(STAGES + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(STAGES);

    edge_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise, fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WARM;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WARM: begin
                if (cnt_q == WARM_LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= level;
        end
    end

    assign rise = level & ~prev_q;
    assign fall = prev_q & ~level;

    // outputs
    always_comb begin
        run      = (state_q == ST_RUN);
        edge_hit = '0;
        if (state_q == ST_RUN) begin
            edge_hit = ((fall_sel & fall) | (~fall_sel & rise)) & ~ana_dis;
        end
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      in_val,
    input  logic [WIDTH-1:0]      edge_hit,
    output logic [WIDTH-1:0]      out_q,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      flag_q,
    output logic [WIDTH-1:0]      edge_q,
    output logic [WIDTH-1:0]      ien_q,
    output logic [WIDTH-1:0]      fsel_q,
    output logic [WIDTH-1:0]      res_q,
    output logic                  irq
);

    gpio_reg_e        ra;
    logic [WIDTH-1:0] flag_base;

    assign ra = gpio_reg_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            edge_q <= '0;
            ien_q  <= '0;
            fsel_q <= '0;
            res_q  <= '0;
        end else if (bus_we) begin
            unique case (ra)
                RA_OUT:  out_q  <= bus_wdata;
                RA_DIR:  dir_q  <= bus_wdata;
                RA_EDGE: edge_q <= bus_wdata;
                RA_IEN:  ien_q  <= bus_wdata;
                RA_FSEL: fsel_q <= bus_wdata;
                RA_RES:  res_q  <= bus_wdata;
                RA_IN, RA_FLAG: ;
            endcase
        end
    end

    // a bus write replaces the flags, a fresh edge is OR-ed on top
    assign flag_base = (bus_we && ra == RA_FLAG) ? bus_wdata : flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_base | edge_hit;
        end
    end

    always_comb begin
        unique case (ra)
            RA_IN:   bus_rdata = in_val;
            RA_OUT:  bus_rdata = out_q;
            RA_DIR:  bus_rdata = dir_q;
            RA_FLAG: bus_rdata = flag_q;
            RA_EDGE: bus_rdata = edge_q;
            RA_IEN:  bus_rdata = ien_q;
            RA_FSEL: bus_rdata = fsel_q;
            RA_RES:  bus_rdata = res_q;
        endcase
    end

    assign irq = |(flag_q & ien_q);

endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] PERIPH_DIR_MASK = '1
) (
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] fsel_q,
    input  logic [WIDTH-1:0] res_q,
    input  logic [WIDTH-1:0] ana_dis,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] per_dir,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pull_en,
    output logic [WIDTH-1:0] pad_pull_up
);

    logic [WIDTH-1:0] eff_dir;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (PERIPH_DIR_MASK[b]) begin : g_periph_dir
            assign eff_dir[b] = fsel_q[b] ? per_dir[b] : dir_q[b];
        end else begin : g_reg_dir
            assign eff_dir[b] = dir_q[b];
        end
        assign pad_out[b]     = fsel_q[b] ? per_out[b] : out_q[b];
        assign pad_oe[b]      = eff_dir[b] & ~ana_dis[b];
        assign pad_pull_en[b] = res_q[b] & ~eff_dir[b] & ~ana_dis[b];
        assign pad_pull_up[b] = out_q[b];
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int               WIDTH           = 8,
    parameter int               SYNC_STAGES     = 2,
    parameter logic [WIDTH-1:0] PERIPH_DIR_MASK = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      pad_in,
    input  logic [WIDTH-1:0]      ana_dis,
    input  logic [WIDTH-1:0]      per_out,
    input  logic [WIDTH-1:0]      per_dir,
    output logic [WIDTH-1:0]      per_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_pull_en,
    output logic [WIDTH-1:0]      pad_pull_up,
    output logic                  irq
);

    logic [WIDTH-1:0] sync_lvl, in_val, edge_hit;
    logic [WIDTH-1:0] out_q, dir_q, flag_q, edge_q, ien_q, fsel_q, res_q;
    logic             edge_run;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_lvl)
    );

    assign in_val = sync_lvl & ~ana_dis;
    assign per_in = in_val;

    gpio_edge #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (sync_lvl),
        .ana_dis  (ana_dis),
        .fall_sel (edge_q),
        .edge_hit (edge_hit),
        .run      (edge_run)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_val    (in_val),
        .edge_hit  (edge_hit),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .flag_q    (flag_q),
        .edge_q    (edge_q),
        .ien_q     (ien_q),
        .fsel_q    (fsel_q),
        .res_q     (res_q),
        .irq       (irq)
    );

    gpio_pad #(.WIDTH(WIDTH), .PERIPH_DIR_MASK(PERIPH_DIR_MASK)) u_pad (
        .out_q       (out_q),
        .dir_q       (dir_q),
        .fsel_q      (fsel_q),
        .res_q       (res_q),
        .ana_dis     (ana_dis),
        .per_out     (per_out),
        .per_dir     (per_dir),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] ana_dis,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pull_en,
    input logic [WIDTH-1:0] flag_q,
    input logic [WIDTH-1:0] ien_q,
    input logic [WIDTH-1:0] edge_hit,
    input logic             edge_run,
    input logic             irq
);

    logic flag_wr;
    assign flag_wr = bus_we && (bus_addr == 3'd3);

    AST_ANA_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_dis & (pad_oe | pad_pull_en)) == '0); // R11

    AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0); // R6

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flag_q & ~$past(bus_wdata) & ~$past(edge_hit)) == '0)); // R9

    AST_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0)); // R7

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|ien_q)); // R10

    AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_run |-> (edge_hit == '0)); // R12

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ana_dis     (ana_dis),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .flag_q      (flag_q),
    .ien_q       (ien_q),
    .edge_hit    (edge_hit),
    .edge_run    (edge_run),
    .irq         (irq)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

    localparam int         W    = 8;
    localparam logic [7:0] MASK = 8'h0F;
    localparam logic [2:0] A_IN = 3'd0, A_OUT = 3'd1, A_DIR = 3'd2, A_FLAG = 3'd3,
                           A_EDGE = 3'd4, A_IEN = 3'd5, A_FSEL = 3'd6, A_RES = 3'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = '0, ana_dis = '0, per_out = '0, per_dir = '0;
    logic [W-1:0] per_in, pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_port_ctrl #(.WIDTH(W), .SYNC_STAGES(2), .PERIPH_DIR_MASK(MASK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .ana_dis(ana_dis), .per_out(per_out), .per_dir(per_dir), .per_in(per_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .irq(irq)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] d, base, pat, exp_oe, exp_pe;
        logic ed, ef, er, ea;

        // R12: pins high through reset must not leave flags behind
        pad_in = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        idle(6);
        rd(A_FLAG, d); check("R12 flag after warm-up", d, 8'h00);
        rd(A_IN, d);   check("R3 input level", d, 8'hFF);
        check("R3 per_in", per_in, 8'hFF);

        // R1 reset state
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), d); check("R1 reset value", d, 8'h00);
        end
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2 register access
        for (int a = 1; a < 8; a++) begin
            pat = 8'h11 * a ^ 8'hA0;
            wr(3'(a), pat);
            rd(3'(a), d); check("R2 readback", d, pat);
            wr(3'(a), 8'h00);
        end
        wr(A_IN, 8'h00);
        rd(A_IN, d); check("R2 input not writable", d, 8'hFF);

        // R3 two-edge input latency
        @(negedge clk); pad_in = 8'h3C;
        @(negedge clk); peek(A_IN, d); check("R3 after one edge", d, 8'hFF);
        @(negedge clk); peek(A_IN, d); check("R3 after two edges", d, 8'h3C);
        check("R3 per_in follows", per_in, 8'h3C);

        // R4 R5 R6 R11 pad control sweep
        per_out = 8'h5A; per_dir = 8'h96;
        wr(A_OUT, 8'hC3);
        for (int c = 0; c < 16; c++) begin
            ed = c[0]; ef = c[1]; er = c[2]; ea = c[3];
            wr(A_DIR, {W{ed}});
            wr(A_FSEL, {W{ef}});
            wr(A_RES, {W{er}});
            @(negedge clk); ana_dis = {W{ea}};
            #2;
            for (int b = 0; b < W; b++) begin
                logic eff;
                eff = (ef && MASK[b]) ? per_dir[b] : ed;
                exp_oe[b] = eff & ~ea;
                exp_pe[b] = er & ~eff & ~ea;
            end
            check(ef ? "R5 pad_out" : "R4 pad_out", pad_out, ef ? 8'h5A : 8'hC3);
            check(ea ? "R11 pad_oe" : (ef ? "R5 pad_oe" : "R4 pad_oe"), pad_oe, exp_oe);
            check(ea ? "R11 pull_en" : "R6 pull_en", pad_pull_en, exp_pe);
            check("R6 pull_up", pad_pull_up, 8'hC3);
        end
        wr(A_DIR, 8'h00); wr(A_FSEL, 8'h00); wr(A_RES, 8'h00); wr(A_OUT, 8'h00);
        @(negedge clk); ana_dis = '0;

        // R7 R10 edge sweep over every bit and both edges
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < W; i++) begin
                base = s ? 8'hFF : 8'h00;
                wr(A_EDGE, base);
                @(negedge clk); pad_in = base;
                idle(4);
                wr(A_FLAG, 8'h00);
                @(negedge clk); pad_in = base ^ (8'h01 << i);
                @(negedge clk);
                @(negedge clk); peek(A_FLAG, d); check("R7 not after two edges", d, 8'h00);
                @(negedge clk); peek(A_FLAG, d); check("R7 flag on chosen edge", d, 8'h01 << i);
                wr(A_IEN, 8'h01 << i);
                #2; check("R10 irq on", {7'b0, irq}, 8'h01);
                wr(A_IEN, ~(8'h01 << i));
                #2; check("R10 irq off", {7'b0, irq}, 8'h00);
                wr(A_IEN, 8'h00);
                @(negedge clk); pad_in = base;
                idle(4);
                peek(A_FLAG, d); check("R7 opposite edge ignored", d, 8'h01 << i);
            end
        end

        // R8 edge-select change alone
        @(negedge clk); pad_in = 8'h0F;
        idle(4);
        wr(A_FLAG, 8'h00);
        wr(A_EDGE, 8'hFF); wr(A_EDGE, 8'h00); wr(A_EDGE, 8'hFF);
        idle(3);
        rd(A_FLAG, d); check("R8 no flag from select change", d, 8'h00);

        // R9 software set and clear, edge beats a clearing write
        wr(A_FLAG, 8'hA5);
        rd(A_FLAG, d); check("R9 software set", d, 8'hA5);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, d); check("R9 software clear", d, 8'h00);
        wr(A_EDGE, 8'h00);
        @(negedge clk); pad_in = 8'h8F;
        @(negedge clk);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, d); check("R9 edge wins over clear", d, 8'h80);

        // R11 analog disable blocks input and edges
        wr(A_FLAG, 8'h00);
        @(negedge clk); ana_dis = 8'h01;
        idle(3);
        rd(A_IN, d); check("R11 input gated", d, 8'h8E);
        @(negedge clk); pad_in = 8'h8E;
        idle(4);
        @(negedge clk); pad_in = 8'h8F;
        idle(4);
        rd(A_FLAG, d); check("R11 no flag while disabled", d, 8'h00);

        finish_run();
    end

endmodule